// File: doc/BRIEF.md
# Touch Pen Contact Debouncer with Event Flags

This block filters a synchronized pen-contact comparator level for a resistive touch controller. A contact or a release is accepted only after the raw level has disagreed with the current filtered state for 2^N consecutive converter clock cycles. N is a 4-bit field, so the window runs from 1 to 32768 cycles. Filtering is suspended while the converter reports a conversion in progress: the qualification count is held at zero and the filtered state is frozen.

Each accepted transition raises one of two sticky event flags. One flag marks a new contact and the other marks a new release. The two flags are mutually exclusive: raising one clears the other. Both flags clear on a status-read strobe. A live bit shows the filtered contact state. An interrupt line is asserted while any flag is set whose enable bit is on. System software can use this line to wake on a touch.

The filter is a four-state machine:
- `ST_OPEN`: settled, no contact.
- `ST_QUAL_TOUCH`: counting toward contact.
- `ST_CLOSED`: settled, contact.
- `ST_QUAL_LIFT`: counting toward release.

Its transitions are:
- open→qual_touch: raw high, not busy, window longer than 1.
- open→closed: raw high, not busy, window of 1.
- qual_touch→open: raw low or busy.
- qual_touch→closed: window complete.
- closed→qual_lift: raw low, not busy, window longer than 1.
- closed→open: raw low, not busy, window of 1.
- qual_lift→closed: raw high or busy.
- qual_lift→open: window complete.

Top module: `pen_contact_filter`

## Requirements
- R1: While `rst_n` is low and after its release, `pen_state`, `flag_touch`, `flag_lift` and `irq` are all 0.
- R2: With `pen_raw`=1 and `conv_busy`=0 on 2^N consecutive cycles (N = `dbnc_exp`, 0..15), the clock edge that ends the last of those cycles sets `pen_state` to 1 and sets `flag_touch`. Before that edge neither output changes.
- R3: With `pen_raw`=0 and `conv_busy`=0 on 2^N consecutive cycles while `pen_state`=1, the edge ending the last of those cycles sets `pen_state` to 0 and sets `flag_lift`.
- R4: A cycle in which `pen_raw` equals the filtered state restarts the qualification count from zero.
- R5: A cycle with `conv_busy`=1 restarts the count and leaves `pen_state` unchanged. Non-busy gaps shorter than 2^N cycles therefore never produce a transition.
- R6: `flag_touch` and `flag_lift` stay set until a cycle with `stat_rd`=1, after whose edge both read 0.
- R7: `flag_touch` and `flag_lift` are never 1 together. Raising either one clears the other.
- R8: When an event and `stat_rd` fall in the same cycle, the flag of that event is 1 after the edge.
- R9: `irq` = (`flag_touch` AND `irq_en[0]`) OR (`flag_lift` AND `irq_en[1]`).
- R10: `pen_state` changes only on an edge that also raises the matching event flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pen_raw | input | 1 | Synchronized comparator level, 1 = contact |
| conv_busy | input | 1 | 1 while any conversion is in progress |
| dbnc_exp | input | 4 | Window exponent N, window = 2^N cycles |
| irq_en | input | 2 | Bit 0 enables contact interrupt, bit 1 enables release interrupt |
| stat_rd | input | 1 | Status-read strobe, clears both flags |
| pen_state | output | 1 | Filtered contact state |
| flag_touch | output | 1 | Sticky contact event flag |
| flag_lift | output | 1 | Sticky release event flag |
| irq | output | 1 | Interrupt request |

## Verification
Two situations are hard to reach from the ports:
- An event edge that coincides with a status read. The bench reaches it with a 1-cycle window (N=0), so a single raw toggle fires an event on a known edge, and it strobes `stat_rd` in that same cycle.
- A busy-chopped input that never qualifies. The bench repeats three idle contact cycles followed by one busy cycle under a 4-cycle window. It then checks that no contact is reported until four uninterrupted idle cycles pass.

The full 32768-cycle window is also checked one cycle before and at its end.

// File: rtl/pen_pkg.sv
package pen_pkg;

    typedef enum logic [1:0] {
        ST_OPEN       = 2'd0,
        ST_QUAL_TOUCH = 2'd1,
        ST_CLOSED     = 2'd2,
        ST_QUAL_LIFT  = 2'd3
    } pen_state_e;

    localparam int IRQ_TOUCH_BIT = 0;
    localparam int IRQ_LIFT_BIT  = 1;

endpackage

// File: rtl/pen_dbnc_fsm.sv
module pen_dbnc_fsm
    import pen_pkg::*;
#(
    parameter int EXP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pen_raw,
    input  logic             conv_busy,
    input  logic [EXP_W-1:0] dbnc_exp,
    output logic             pen_state,
    output logic             evt_touch,
    output logic             evt_lift
);
    localparam int MAX_EXP = (1 << EXP_W) - 1;
    localparam int CNT_W   = MAX_EXP + 1;

    pen_state_e       state_q, state_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic [CNT_W-1:0] last_cnt;

    assign last_cnt = (CNT_W'(1) << dbnc_exp) - CNT_W'(1);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OPEN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
        end
    end

    // next state
    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        unique case (state_q)
            ST_OPEN: begin
                cnt_n = '0;
                if (!conv_busy && pen_raw) begin
                    if (last_cnt == '0) begin
                        state_n = ST_CLOSED;
                    end else begin
                        state_n = ST_QUAL_TOUCH;
                        cnt_n   = CNT_W'(1);
                    end
                end
            end
            ST_QUAL_TOUCH: begin
                if (conv_busy || !pen_raw) begin
                    state_n = ST_OPEN;
                    cnt_n   = '0;
                end else if (cnt_q >= last_cnt) begin
                    state_n = ST_CLOSED;
                    cnt_n   = '0;
                end else begin
                    cnt_n = cnt_q + CNT_W'(1);
                end
            end
            ST_CLOSED: begin
                cnt_n = '0;
                if (!conv_busy && !pen_raw) begin
                    if (last_cnt == '0) begin
                        state_n = ST_OPEN;
                    end else begin
                        state_n = ST_QUAL_LIFT;
                        cnt_n   = CNT_W'(1);
                    end
                end
            end
            ST_QUAL_LIFT: begin
                if (conv_busy || pen_raw) begin
                    state_n = ST_CLOSED;
                    cnt_n   = '0;
                end else if (cnt_q >= last_cnt) begin
                    state_n = ST_OPEN;
                    cnt_n   = '0;
                end else begin
                    cnt_n = cnt_q + CNT_W'(1);
                end
            end
            default: begin
                state_n = ST_OPEN;
                cnt_n   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        pen_state = (state_q == ST_CLOSED) || (state_q == ST_QUAL_LIFT);
        evt_touch = (state_n == ST_CLOSED) &&
                    ((state_q == ST_OPEN) || (state_q == ST_QUAL_TOUCH));
        evt_lift  = (state_n == ST_OPEN) &&
                    ((state_q == ST_CLOSED) || (state_q == ST_QUAL_LIFT));
    end

    // busy freezes the filtered state
    assert_busy_freeze_R5: assert property (@(posedge clk) disable iff (!rst_n)
        conv_busy |=> $stable(pen_state));

    // settled states always hold a cleared count
    assert_settled_cnt_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_OPEN) || (state_q == ST_CLOSED)) |-> (cnt_q == '0));

    // a busy cycle restarts counting
    assert_busy_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        conv_busy |=> (cnt_q == '0));

endmodule

// File: rtl/pen_event_flags.sv
module pen_event_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_touch,
    input  logic evt_lift,
    input  logic stat_rd,
    output logic flag_touch,
    output logic flag_lift
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_touch <= 1'b0;
            flag_lift  <= 1'b0;
        end else if (evt_touch) begin
            flag_touch <= 1'b1;
            flag_lift  <= 1'b0;
        end else if (evt_lift) begin
            flag_touch <= 1'b0;
            flag_lift  <= 1'b1;
        end else if (stat_rd) begin
            flag_touch <= 1'b0;
            flag_lift  <= 1'b0;
        end
    end

    assert_flags_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(flag_touch && flag_lift));

    assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !evt_touch && !evt_lift) |=> (!flag_touch && !flag_lift));

    assert_touch_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        evt_touch |=> (flag_touch && !flag_lift));

    assert_lift_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        evt_lift |=> (flag_lift && !flag_touch));

    assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_touch && !stat_rd && !evt_lift) |=> flag_touch);

endmodule

// File: rtl/pen_irq_gen.sv
module pen_irq_gen
    import pen_pkg::*;
(
    input  logic       flag_touch,
    input  logic       flag_lift,
    input  logic [1:0] irq_en,
    output logic       irq
);

    always_comb begin
        irq = (flag_touch && irq_en[IRQ_TOUCH_BIT]) ||
              (flag_lift  && irq_en[IRQ_LIFT_BIT]);
    end

endmodule

// File: rtl/pen_contact_filter.sv
module pen_contact_filter #(
    parameter int EXP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pen_raw,
    input  logic             conv_busy,
    input  logic [EXP_W-1:0] dbnc_exp,
    input  logic [1:0]       irq_en,
    input  logic             stat_rd,
    output logic             pen_state,
    output logic             flag_touch,
    output logic             flag_lift,
    output logic             irq
);

    logic evt_touch;
    logic evt_lift;

    pen_dbnc_fsm #(.EXP_W(EXP_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pen_raw   (pen_raw),
        .conv_busy (conv_busy),
        .dbnc_exp  (dbnc_exp),
        .pen_state (pen_state),
        .evt_touch (evt_touch),
        .evt_lift  (evt_lift)
    );

    pen_event_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_touch  (evt_touch),
        .evt_lift   (evt_lift),
        .stat_rd    (stat_rd),
        .flag_touch (flag_touch),
        .flag_lift  (flag_lift)
    );

    pen_irq_gen u_irq (
        .flag_touch (flag_touch),
        .flag_lift  (flag_lift),
        .irq_en     (irq_en),
        .irq        (irq)
    );

    // filtered state only moves together with its event flag
    assert_state_rise_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pen_state) |-> flag_touch);

    assert_state_fall_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pen_state) |-> flag_lift);

endmodule

// File: tb/pen_contact_filter_tb.sv
module pen_contact_filter_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pen_raw = 1'b0;
    logic       conv_busy = 1'b0;
    logic [3:0] dbnc_exp = 4'd0;
    logic [1:0] irq_en = 2'b11;
    logic       stat_rd = 1'b0;
    logic       pen_state, flag_touch, flag_lift, irq;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    pen_contact_filter u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .pen_raw    (pen_raw),
        .conv_busy  (conv_busy),
        .dbnc_exp   (dbnc_exp),
        .irq_en     (irq_en),
        .stat_rd    (stat_rd),
        .pen_state  (pen_state),
        .flag_touch (flag_touch),
        .flag_lift  (flag_lift),
        .irq        (irq)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            failures = failures + 1;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected<150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
            $finish;
        end
    end

    // vector: {raw, busy, rd, exp_state, exp_touch, exp_lift}, window N=2
    localparam logic [5:0] VEC [13] = '{
        6'b100_000, 6'b100_000, 6'b100_000, 6'b100_110,
        6'b001_100, 6'b010_100, 6'b000_100, 6'b000_100,
        6'b000_100, 6'b000_001, 6'b100_001, 6'b000_001,
        6'b101_000
    };

    task automatic check(input string req, input logic es, input logic et, input logic el);
        logic ei;
        ei = (et & irq_en[0]) | (el & irq_en[1]);
        checks = checks + 1;
        if ({pen_state, flag_touch, flag_lift, irq} !== {es, et, el, ei}) begin
            failures = failures + 1;
            $display("FAIL %s: actual state/touch/lift/irq=%b%b%b%b expected=%b%b%b%b",
                     req, pen_state, flag_touch, flag_lift, irq, es, et, el, ei);
        end
    endtask

    task automatic step(input logic raw, input logic busy, input logic rd);
        @(negedge clk);
        pen_raw   = raw;
        conv_busy = busy;
        stat_rd   = rd;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #1;
        check("R1 in reset", 1'b0, 1'b0, 1'b0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        dbnc_exp = 4'd2;
        @(posedge clk);
        #1;
        check("R1 after reset", 1'b0, 1'b0, 1'b0);

        // table walk: R2 R3 R4 R5 R6 R7
        for (int i = 0; i < 13; i++) begin
            step(VEC[i][5], VEC[i][4], VEC[i][3]);
            check($sformatf("R2/R3/R4/R5/R6/R7 vector %0d", i),
                  VEC[i][2], VEC[i][1], VEC[i][0]);
        end
        step(1'b0, 1'b0, 1'b0);
        check("R4 abort to open", 1'b0, 1'b0, 1'b0);

        // R5: busy-chopped windows never qualify
        for (int k = 0; k < 4; k++) begin
            step(1'b1, 1'b0, 1'b0);
            step(1'b1, 1'b0, 1'b0);
            step(1'b1, 1'b0, 1'b0);
            step(1'b1, 1'b1, 1'b0);
        end
        check("R5 short gaps ignored", 1'b0, 1'b0, 1'b0);
        for (int k = 0; k < 4; k++) step(1'b1, 1'b0, 1'b0);
        check("R2 after busy clears", 1'b1, 1'b1, 1'b0);

        // R8: event and read in the same cycle, N=0
        dbnc_exp = 4'd0;
        step(1'b0, 1'b0, 1'b1);
        check("R8 lift beats read", 1'b0, 1'b0, 1'b1);
        step(1'b1, 1'b0, 1'b1);
        check("R8 touch beats read", 1'b1, 1'b1, 1'b0);

        // R9: masking
        irq_en = 2'b01;
        #1;
        check("R9 touch enabled", 1'b1, 1'b1, 1'b0);
        step(1'b0, 1'b0, 1'b0);
        check("R9 lift masked", 1'b0, 1'b0, 1'b1);
        irq_en = 2'b10;
        #1;
        check("R9 lift enabled", 1'b0, 1'b0, 1'b1);
        irq_en = 2'b00;
        #1;
        check("R9 all masked", 1'b0, 1'b0, 1'b1);
        irq_en = 2'b11;

        // R6: plain read clears
        step(1'b0, 1'b0, 1'b1);
        check("R6 read clears", 1'b0, 1'b0, 1'b0);

        // R2: full window, N=15
        dbnc_exp = 4'd15;
        for (int k = 0; k < 32767; k++) step(1'b1, 1'b0, 1'b0);
        check("R2 N=15 one short", 1'b0, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b0);
        check("R2 N=15 complete", 1'b1, 1'b1, 1'b0);

        // R4 / R10: interrupted release, N=1
        dbnc_exp = 4'd1;
        step(1'b0, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b0);
        check("R4 restart holds state", 1'b1, 1'b1, 1'b0);
        step(1'b0, 1'b0, 1'b0);
        check("R3/R10 release after restart", 1'b0, 1'b0, 1'b1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule